// File: doc/BRIEF.md
# Character Display Address Counter

This block keeps the RAM address for a character display controller. It covers the two RAM spaces: the display RAM, whose legal addresses depend on whether the panel runs as one line or as two, and the 64-entry glyph RAM. The instruction decoder drives address loads, cursor moves and display shifts into the block. The data port reports each finished RAM access. The block keeps the counter inside the legal ranges, advances it in the direction the entry mode selects, and tracks how far the visible window has been shifted along a line.

Reads go through a one-entry prefetch register rather than straight to the RAM. The register is refilled one cycle after an address load, a cursor move or a read. A write does not refill it, so a read that follows a write returns the old contents. The RAM arrays sit next to the block. Their combinational read port is fed by the block's address and space select.

Top module: `ddram_addr_ctr`

## Requirements
- R1: After reset the address is 00h, the display RAM space is selected, the shift offset is 0 and the prefetch output is 00h.
- R2: A display-RAM load selects that space and sets the address. An illegal value maps to the start of its line: 28h-3Fh to 00h and 68h-7Fh to 40h in two-line mode, and 50h-7Fh to 00h in one-line mode. A glyph-RAM load selects the glyph space and sets the address to bits 5:0 of the value.
- R3: In one-line mode the display address steps through 00h-4Fh. It wraps from 4Fh up to 00h and from 00h down to 4Fh.
- R4: In two-line mode, stepping up goes from 27h to 40h and from 67h to 00h. Stepping down goes from 40h to 27h and from 00h to 67h.
- R5: In the glyph space the address steps modulo 64.
- R6: Every completed access, read or write, moves the address one step: up when the increment input is 1 and down when it is 0.
- R7: A move request with the display bit 0 moves the cursor: one step right (up) when the right bit is 1, one step left (down) when it is 0.
- R8: A move request with the display bit 1 leaves the address unchanged. It changes the offset by +1 for a left shift (right bit 0) or by -1 for a right shift, modulo 40 in two-line mode and 80 in one-line mode.
- R9: A completed display-RAM write with auto-shift enabled also shifts the display: left (+1) when incrementing and right (-1) when decrementing. Reads and glyph-RAM writes never shift the display.
- R10: The prefetch output takes the RAM data at the current address one cycle after a load, a cursor move or a completed read. A completed write leaves it unchanged.
- R11: When the line mode input changes, the block spends that cycle re-syncing. It maps a display address into the new legal range as in R2, clears the offset, and ignores any request in that cycle.
- R12: When several requests arrive in one cycle, a load wins over a move request, which wins over an access completion. A glyph load wins over a display load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| two_line | input | 1 | 1 selects two-line addressing |
| inc_dir | input | 1 | Entry direction: 1 up, 0 down |
| shift_en | input | 1 | Display shifts on each display-RAM write |
| ld_dd | input | 1 | Load a display RAM address |
| ld_cg | input | 1 | Load a glyph RAM address |
| ld_val | input | 7 | Address to load |
| mv_req | input | 1 | Cursor or display move request |
| mv_disp | input | 1 | 1 shifts the display, 0 moves the cursor |
| mv_right | input | 1 | Move direction: 1 right, 0 left |
| acc_done | input | 1 | A RAM access completed |
| acc_wr | input | 1 | The completed access was a write |
| ram_rdata | input | DW | RAM read data at the current address |
| ac_addr | output | 7 | Current RAM address |
| cg_sel | output | 1 | 1 when the glyph RAM is addressed |
| view_ofs | output | 7 | Display shift offset, 0 to line length minus 1 |
| rd_data | output | DW | Prefetch register contents |

## Verification
The hardest case to reach is a stale prefetch. It appears only when a write follows a refilled read, and it can be seen only by comparing the data the next read gets against RAM contents that the write has just changed. The bench loads an address, reads to force a refill, writes new data to the following location, and then checks that the prefetch output still holds the value the read fetched. The wrap points of both line modes are reached by loading each legal address in turn and stepping from there in both directions. Offset wraps are reached by runs of more than a full line length of shifts.

// File: rtl/ddram_addr_ctr.sv
module ddram_addr_ctr #(
  parameter int DW    = 8,
  parameter int LINE1 = 80,
  parameter int LINE2 = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          two_line,
  input  logic          inc_dir,
  input  logic          shift_en,
  input  logic          ld_dd,
  input  logic          ld_cg,
  input  logic [6:0]    ld_val,
  input  logic          mv_req,
  input  logic          mv_disp,
  input  logic          mv_right,
  input  logic          acc_done,
  input  logic          acc_wr,
  input  logic [DW-1:0] ram_rdata,
  output logic [6:0]    ac_addr,
  output logic          cg_sel,
  output logic [6:0]    view_ofs,
  output logic [DW-1:0] rd_data
);
  localparam logic [6:0] L1_END = 7'(LINE1 - 1);
  localparam logic [6:0] L2_END = 7'(LINE2 - 1);
  localparam logic [6:0] L2_BASE = 7'h40;
  localparam logic [6:0] L2_TOP = L2_BASE + L2_END;

  logic mode_q, pend;

  wire resync = two_line != mode_q;
  wire do_ld  = !resync && (ld_dd || ld_cg);
  wire do_mv  = !resync && !do_ld && mv_req;
  wire do_acc = !resync && !do_ld && !mv_req && acc_done;
  wire [6:0] len_m1 = mode_q ? L2_END : L1_END;

  function automatic logic [6:0] legalize(input logic [6:0] a, input logic two);
    if (two) begin
      if (!a[6] && a > L2_END) return 7'h00;
      if (a[6] && a > L2_TOP) return L2_BASE;
      return a;
    end
    return (a > L1_END) ? 7'h00 : a;
  endfunction

  function automatic logic [6:0] step(input logic [6:0] a, input logic up,
                                      input logic two, input logic cg);
    if (cg) return {1'b0, up ? a[5:0] + 6'd1 : a[5:0] - 6'd1};
    if (two) begin
      if (up) return (a == L2_END) ? L2_BASE : (a == L2_TOP) ? 7'h00 : a + 7'd1;
      return (a == L2_BASE) ? L2_END : (a == 7'h00) ? L2_TOP : a - 7'd1;
    end
    if (up) return (a == L1_END) ? 7'h00 : a + 7'd1;
    return (a == 7'h00) ? L1_END : a - 7'd1;
  endfunction

  function automatic logic [6:0] slide(input logic [6:0] o, input logic left,
                                       input logic [6:0] lim);
    if (left) return (o == lim) ? 7'h00 : o + 7'd1;
    return (o == 7'h00) ? lim : o - 7'd1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_addr  <= '0;
      cg_sel   <= 1'b0;
      view_ofs <= '0;
      rd_data  <= '0;
      mode_q   <= 1'b0;
      pend     <= 1'b0;
    end else begin
      pend <= do_ld || (do_mv && !mv_disp) || (do_acc && !acc_wr);
      if (pend) rd_data <= ram_rdata;
      if (resync) begin
        mode_q   <= two_line;
        view_ofs <= '0;
        if (!cg_sel) ac_addr <= legalize(ac_addr, two_line);
      end else if (do_ld) begin
        cg_sel  <= ld_cg;
        ac_addr <= ld_cg ? {1'b0, ld_val[5:0]} : legalize(ld_val, mode_q);
      end else if (do_mv) begin
        if (mv_disp) view_ofs <= slide(view_ofs, !mv_right, len_m1);
        else         ac_addr  <= step(ac_addr, mv_right, mode_q, cg_sel);
      end else if (do_acc) begin
        ac_addr <= step(ac_addr, inc_dir, mode_q, cg_sel);
        if (acc_wr && shift_en && !cg_sel) view_ofs <= slide(view_ofs, inc_dir, len_m1);
      end
    end
  end

  // R2
  addr_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cg_sel ? (ac_addr < 7'd64)
           : (mode_q ? (ac_addr <= L2_END || (ac_addr >= L2_BASE && ac_addr <= L2_TOP))
                     : ac_addr <= L1_END));

  // R4
  line_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_acc && !cg_sel && mode_q && inc_dir && ac_addr == L2_END) |=> ac_addr == L2_BASE);

  // R5
  cg_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_acc && cg_sel && inc_dir && ac_addr == 7'd63) |=> ac_addr == 7'd0);

  // R8
  disp_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_mv && mv_disp) |=> ($stable(ac_addr) && !$stable(view_ofs)));

  // R10
  wr_stale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_acc && acc_wr && !pend) |=> $stable(rd_data));
endmodule

// File: tb/ddram_addr_ctr_test.sv
module ddram_addr_ctr_test;
  logic clk = 0, rst_n = 0;
  logic two_line = 0, inc_dir = 1, shift_en = 0, ld_dd = 0, ld_cg = 0;
  logic [6:0] ld_val = 0;
  logic mv_req = 0, mv_disp = 0, mv_right = 0, acc_done = 0, acc_wr = 0;
  logic [7:0] ram_rdata, wdata = 0;
  logic [6:0] ac_addr, view_ofs;
  logic cg_sel;
  logic [7:0] rd_data;
  logic [7:0] dd [128];
  logic [7:0] cg [64];
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  ddram_addr_ctr uut (.clk, .rst_n, .two_line, .inc_dir, .shift_en, .ld_dd, .ld_cg,
    .ld_val, .mv_req, .mv_disp, .mv_right, .acc_done, .acc_wr, .ram_rdata,
    .ac_addr, .cg_sel, .view_ofs, .rd_data);

  assign ram_rdata = cg_sel ? cg[ac_addr[5:0]] : dd[ac_addr];
  always @(posedge clk)
    if (acc_done && acc_wr && !ld_dd && !ld_cg && !mv_req) begin
      if (cg_sel) cg[ac_addr[5:0]] <= wdata;
      else dd[ac_addr] <= wdata;
    end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int nxt(input int a, input bit up, input bit two);
    int i;
    if (!two) return (a + (up ? 1 : 79)) % 80;
    i = (a >= 64) ? a - 24 : a;
    i = (i + (up ? 1 : 79)) % 80;
    return (i >= 40) ? i + 24 : i;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input bit g, input int v);
    @(negedge clk); ld_cg = g; ld_dd = !g; ld_val = 7'(v);
    @(negedge clk); ld_cg = 0; ld_dd = 0;
    idle(1);
  endtask

  task automatic move(input bit d, input bit r);
    @(negedge clk); mv_req = 1; mv_disp = d; mv_right = r;
    @(negedge clk); mv_req = 0;
    idle(1);
  endtask

  task automatic access(input bit w, input bit up, input int data);
    @(negedge clk); acc_done = 1; acc_wr = w; inc_dir = up; wdata = 8'(data);
    @(negedge clk); acc_done = 0;
    idle(1);
  endtask

  initial begin
    int a, e, v;
    for (int i = 0; i < 128; i++) dd[i] = 8'(i) ^ 8'h5A;
    for (int i = 0; i < 64; i++) cg[i] = 8'(i) + 8'h80;
    idle(2); rst_n = 1; idle(1);
    check("R1 addr", ac_addr, 0); check("R1 cg", cg_sel, 0);
    check("R1 ofs", view_ofs, 0); check("R1 data", rd_data, 0);

    for (int t = 0; t < 2; t++) begin
      two_line = t[0]; idle(2);
      for (int i = 0; i < 80; i++) begin
        a = (t == 1 && i >= 40) ? i + 24 : i;
        load(0, a);
        check("R2 load", ac_addr, a); check("R10 refill", rd_data, dd[a]);
        move(0, 1);
        check(t ? "R4/R7 right" : "R3/R7 right", ac_addr, nxt(a, 1, t[0]));
        move(0, 0);
        check("R7 left", ac_addr, a);
        access(0, 0, 0);
        check(t ? "R4/R6 down" : "R3/R6 down", ac_addr, nxt(a, 0, t[0]));
      end
    end

    two_line = 1; idle(2);
    load(0, 'h30); check("R2 fix low", ac_addr, 0);
    load(0, 'h70); check("R2 fix high", ac_addr, 'h40);
    two_line = 0; idle(2);
    load(0, 'h55); check("R2 fix one", ac_addr, 0);

    for (int i = 0; i < 64; i++) begin
      load(1, i + 64);
      check("R2 cg load", ac_addr, i); check("R2 cg sel", cg_sel, 1);
      access(0, 1, 0);
      check("R5 cg up", ac_addr, (i + 1) % 64);
      access(1, 0, 0);
      check("R5 cg down", ac_addr, i);
    end

    two_line = 1; idle(2); load(0, 'h12);
    for (int i = 0; i < 45; i++) move(1, 0);
    check("R8 left wrap", view_ofs, 5); check("R8 addr kept", ac_addr, 'h12);
    for (int i = 0; i < 7; i++) move(1, 1);
    check("R8 right wrap", view_ofs, 38);
    shift_en = 1;
    access(1, 1, 'h11); check("R9 inc shift", view_ofs, 39);
    access(1, 0, 'h22); check("R9 dec shift", view_ofs, 38);
    access(0, 1, 0); check("R9 read no shift", view_ofs, 38);
    load(1, 3); access(1, 1, 'h33); check("R9 cg no shift", view_ofs, 38);
    shift_en = 0;
    two_line = 0; idle(2); check("R11 ofs clear", view_ofs, 0);
    load(0, 0);
    for (int i = 0; i < 85; i++) move(1, 0);
    check("R8 one-line wrap", view_ofs, 5);

    load(0, 'h20);
    access(0, 1, 0); check("R10 read refill", rd_data, dd['h21]);
    v = dd['h21];
    access(1, 1, 'hC3); check("R10 written", dd['h21], 'hC3);
    check("R10 stale", rd_data, v);
    check("R6 after write", ac_addr, 'h22);

    two_line = 1; idle(2); load(0, 'h65); move(1, 0);
    two_line = 0; idle(2);
    check("R11 one fix", ac_addr, 0); check("R11 ofs", view_ofs, 0);
    load(0, 'h4A); two_line = 1; idle(2); check("R11 two keep", ac_addr, 'h4A);

    @(negedge clk); ld_dd = 1; ld_val = 7'h05; mv_req = 1; mv_disp = 0; mv_right = 1;
    @(negedge clk); ld_dd = 0; mv_req = 0; idle(1);
    check("R12 load wins", ac_addr, 5);
    @(negedge clk); mv_req = 1; mv_right = 1; acc_done = 1; acc_wr = 0; inc_dir = 1;
    @(negedge clk); mv_req = 0; acc_done = 0; idle(1);
    check("R12 move wins", ac_addr, 6);
    @(negedge clk); ld_dd = 1; ld_cg = 1; ld_val = 7'h4B;
    @(negedge clk); ld_dd = 0; ld_cg = 0; idle(1);
    e = 'h0B;
    check("R12 cg wins", ac_addr, e); check("R12 cg sel", cg_sel, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule